// File: doc/BRIEF.md
# Audio Codec Interrupt Event Controller

This block collects status events from an audio DAC (loss or gain of PLL frequency lock, headphone amplifier ready, minimum volume reached, overcurrent on the left or right headphone output) and the level of a general-purpose input pin. It sets one sticky interrupt flag, `alert`, when an event whose enable bit is set occurs. Software reads the status byte to find the cause, and a read-clear strobe clears both the event flags and the flag.

All event inputs pass through a two-flop synchroniser before edge detection. A change on the synchronised general-purpose input can also raise the flag. That input's level is returned in the status byte. The general-purpose output can be set to give a single-cycle pulse each time the flag goes from clear to set, so an external controller can use it as an interrupt line.

Top module: `codec_irq_ctrl`

## Requirements
- R1: After reset `alert` and `gpio_out` are 0 and `status` reads 0x00.
- R2: Status layout: lock event at bit 5, headphone-ready at bit 4, minimum-volume at bit 3, left overcurrent at bit 1, right overcurrent at bit 0. These bits are sticky, are set by their event whatever the enable bits hold, and are cleared by `rd_clr`. Bits 7 and 2 read 0.
- R3: The enable register is written with `en_we`/`en_wdata`, one cycle before it takes effect. It uses the same bit positions as the status byte, plus bit 6 for a general-purpose input change. An event sets `alert` only when its enable bit is 1.
- R4: Both a rising and a falling edge of `lock_in` are lock events.
- R5: Headphone-ready, minimum-volume and overcurrent events trigger on the rising edge of their input only. A falling edge has no effect.
- R6: Status bit 6 shows the synchronised `gpio_in` level and is not cleared by `rd_clr`. An input change present before clock edge k appears in status bit 6 after edge k+1, and in the event flags and `alert` after edge k+2.
- R7: With enable bit 6 at 1, any change of the synchronised `gpio_in` level sets `alert`. With enable bit 6 at 0, such a change does not set `alert`.
- R8: `alert` stays at 1 until `rd_clr`. An enabled event in the same cycle as `rd_clr` keeps `alert` at 1 and sets its own status bit, while the older bits clear.
- R9: When `gpio_mode` is 2'b10 or 2'b11, `gpio_out` is 1 for exactly one cycle, starting in the same cycle that `alert` goes from 0 to 1. For 2'b00 and 2'b01 it stays 0.
- R10: No new pulse is given while `alert` stays at 1, even when further enabled events arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lock_in | input | 1 | PLL frequency-lock level |
| hp_ready_in | input | 1 | Headphone amplifier ready level |
| min_vol_in | input | 1 | Minimum volume reached level |
| oc_left_in | input | 1 | Left output overcurrent level |
| oc_right_in | input | 1 | Right output overcurrent level |
| gpio_in | input | 1 | General-purpose pin input level |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data |
| gpio_mode | input | 2 | General-purpose output mode; bit 1 high selects pulse-on-alert |
| rd_clr | input | 1 | Status read-clear strobe |
| status | output | 8 | Status byte |
| alert | output | 1 | Sticky interrupt flag |
| gpio_out | output | 1 | General-purpose output pulse |

## Verification
The case that needs care is a read-clear strobe landing in the same cycle that a new enabled event is registered. The clear must not drop the flag, and the older status bit must go while the new one stays. The bench sets `alert` with a left overcurrent, then raises the right overcurrent two cycles before pulsing `rd_clr`, so both reach the register stage on the same edge. It then expects `alert` still set, status 0x41 and no output pulse in that cycle and the next. The same setup also checks that a pulse is not repeated while the flag is held.

// File: rtl/codec_irq_pkg.sv
package codec_irq_pkg;
  localparam int EVW = 8;
  localparam int B_GPIO = 6;
  localparam int B_LOCK = 5;
  localparam int B_HPRD = 4;
  localparam int B_MVOL = 3;
  localparam int B_OCL  = 1;
  localparam int B_OCR  = 0;
  // Detection kind per status position
  localparam logic [EVW-1:0] RISE_MASK   = (EVW'(1) << B_HPRD) | (EVW'(1) << B_MVOL)
                                         | (EVW'(1) << B_OCL)  | (EVW'(1) << B_OCR);
  localparam logic [EVW-1:0] BOTH_MASK   = (EVW'(1) << B_LOCK) | (EVW'(1) << B_GPIO);
  localparam logic [EVW-1:0] STICKY_MASK = RISE_MASK | (EVW'(1) << B_LOCK);
  localparam logic [EVW-1:0] LEVEL_MASK  = EVW'(1) << B_GPIO;
  localparam logic [EVW-1:0] EN_MASK     = RISE_MASK | BOTH_MASK;
endpackage

// File: rtl/codec_irq_sync.sv
module codec_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/codec_irq_detect.sv
module codec_irq_detect
  import codec_irq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [EVW-1:0] lvl,
  output logic [EVW-1:0] evt
);
  logic [EVW-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar b = 0; b < EVW; b++) begin : g_bit
    if (BOTH_MASK[b]) begin : g_both
      assign evt[b] = lvl[b] ^ prev_q[b];
    end else if (RISE_MASK[b]) begin : g_rise
      assign evt[b] = lvl[b] & ~prev_q[b];
    end else begin : g_none
      assign evt[b] = 1'b0;
    end
  end

  AST_LOCK_BOTH_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[B_LOCK] != prev_q[B_LOCK]) |-> evt[B_LOCK]); // R4
  AST_FALL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl[B_OCL] && prev_q[B_OCL]) |-> !evt[B_OCL]); // R5
endmodule

// File: rtl/codec_irq_core.sv
module codec_irq_core
  import codec_irq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [EVW-1:0] evt,
  input  logic [EVW-1:0] lvl,
  input  logic [EVW-1:0] en,
  input  logic [1:0]     mode,
  input  logic           rd_clr,
  output logic [EVW-1:0] status,
  output logic           alert,
  output logic           pulse
);
  logic [EVW-1:0] flags_q, flags_d;
  logic           alert_q, alert_d;
  logic           pulse_q, pulse_d;
  logic           hit;

  always_comb begin
    hit     = |(evt & en);
    flags_d = (rd_clr ? '0 : flags_q) | (evt & STICKY_MASK);
    alert_d = (rd_clr ? 1'b0 : alert_q) | hit;
    pulse_d = hit & ~alert_q & mode[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      alert_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      flags_q <= flags_d;
      alert_q <= alert_d;
      pulse_q <= pulse_d;
    end
  end

  assign status = (flags_q & STICKY_MASK) | (lvl & LEVEL_MASK);
  assign alert  = alert_q;
  assign pulse  = pulse_q;

  AST_ALERT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_q && !rd_clr) |=> alert_q); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !(|(evt & en))) |=> !alert_q); // R8
  AST_ENABLED_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_q && !(|(evt & en))) |=> !alert_q); // R3
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R9
  AST_PULSE_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (alert_q && !$past(alert_q) && $past(mode[1]))); // R10
endmodule

// File: rtl/codec_irq_ctrl.sv
module codec_irq_ctrl
  import codec_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lock_in,
  input  logic           hp_ready_in,
  input  logic           min_vol_in,
  input  logic           oc_left_in,
  input  logic           oc_right_in,
  input  logic           gpio_in,
  input  logic           en_we,
  input  logic [EVW-1:0] en_wdata,
  input  logic [1:0]     gpio_mode,
  input  logic           rd_clr,
  output logic [EVW-1:0] status,
  output logic           alert,
  output logic           gpio_out
);
  logic [1:0]     rst_pipe_q;
  logic           rst_s_n;
  logic [EVW-1:0] raw, lvl, evt;
  logic [EVW-1:0] en_q, en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  always_comb begin
    raw         = '0;
    raw[B_GPIO] = gpio_in;
    raw[B_LOCK] = lock_in;
    raw[B_HPRD] = hp_ready_in;
    raw[B_MVOL] = min_vol_in;
    raw[B_OCL]  = oc_left_in;
    raw[B_OCR]  = oc_right_in;
  end

  always_comb begin
    en_d = en_q;
    if (en_we) en_d = en_wdata & EN_MASK;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) en_q <= '0;
    else          en_q <= en_d;
  end

  codec_irq_sync #(.W(EVW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .d(raw), .q(lvl)
  );

  codec_irq_detect u_detect (
    .clk(clk), .rst_n(rst_s_n), .lvl(lvl), .evt(evt)
  );

  codec_irq_core u_core (
    .clk(clk), .rst_n(rst_s_n), .evt(evt), .lvl(lvl), .en(en_q),
    .mode(gpio_mode), .rd_clr(rd_clr),
    .status(status), .alert(alert), .pulse(gpio_out)
  );

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_s_n)
    (status[7] == 1'b0) && (status[2] == 1'b0)); // R2
  AST_NO_PULSE_LOW_MODE: assert property (@(posedge clk) disable iff (!rst_s_n)
    !gpio_mode[1] |=> !gpio_out); // R9
endmodule

// File: tb/codec_irq_ctrl_bench.sv
module codec_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       lock_in, hp_ready_in, min_vol_in, oc_left_in, oc_right_in, gpio_in;
  logic       en_we, rd_clr;
  logic [7:0] en_wdata;
  logic [1:0] gpio_mode;
  logic [7:0] status;
  logic       alert, gpio_out;

  typedef struct {
    int         due;
    logic       a;
    logic       g;
    logic [7:0] s;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  codec_irq_ctrl u_codec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .hp_ready_in(hp_ready_in),
    .min_vol_in(min_vol_in), .oc_left_in(oc_left_in), .oc_right_in(oc_right_in),
    .gpio_in(gpio_in), .en_we(en_we), .en_wdata(en_wdata), .gpio_mode(gpio_mode),
    .rd_clr(rd_clr), .status(status), .alert(alert), .gpio_out(gpio_out)
  );

  task automatic push(int d, logic a, logic g, logic [7:0] s, string tag);
    exp_t e;
    e.due = d; e.a = a; e.g = g; e.s = s; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_en(logic [7:0] v);
    en_we = 1'b1; en_wdata = v;
    idle(1);
    en_we = 1'b0;
    idle(1);
  endtask

  task automatic clear(logic [7:0] s_after, string tag);
    rd_clr = 1'b1;
    push(cyc + 1, 1'b0, 1'b0, s_after, tag);
    idle(1);
    rd_clr = 1'b0;
    idle(2);
  endtask

  // Monitor: compares queued expectations when they fall due
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (e.due != cyc || alert !== e.a || gpio_out !== e.g || status !== e.s) begin
          errors++;
          $display("FAIL %s: alert=%0b gpio_out=%0b status=%02h cyc=%0d, expected alert=%0b gpio_out=%0b status=%02h cyc=%0d",
                   e.tag, alert, gpio_out, status, cyc, e.a, e.g, e.s, e.due);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {lock_in, hp_ready_in, min_vol_in, oc_left_in, oc_right_in, gpio_in} = '0;
    en_we = 1'b0; en_wdata = '0; gpio_mode = 2'b00; rd_clr = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    push(cyc + 1, 1'b0, 1'b0, 8'h00, "R1 reset state");
    idle(2);

    // R3 masking and R2 flag set without enable
    gpio_mode = 2'b01;
    write_en(8'h10);
    min_vol_in = 1'b1;
    push(cyc + 3, 1'b0, 1'b0, 8'h08, "R3 masked event, R2 bit 3 set");
    idle(5);
    clear(8'h00, "R2 rd_clr clears flags");

    // R5 rising edge, R9 mode 01 no pulse, R8 sticky
    hp_ready_in = 1'b1;
    push(cyc + 3, 1'b1, 1'b0, 8'h10, "R5 R9 enabled hp event, mode 01 no pulse");
    push(cyc + 4, 1'b1, 1'b0, 8'h10, "R8 alert held");
    idle(6);
    clear(8'h00, "R8 rd_clr clears alert");

    // R4 lock rising edge, R9 pulse in mode 10
    gpio_mode = 2'b10;
    write_en(8'h23);
    lock_in = 1'b1;
    push(cyc + 3, 1'b1, 1'b1, 8'h20, "R4 R9 lock rise pulse");
    push(cyc + 4, 1'b1, 1'b0, 8'h20, "R9 pulse one cycle");
    idle(5);

    // R10 no repeat while alert held
    oc_left_in = 1'b1;
    push(cyc + 3, 1'b1, 1'b0, 8'h22, "R10 no repeat pulse");
    idle(5);
    clear(8'h00, "R8 clear");

    // R4 falling lock, mode 11
    gpio_mode = 2'b11;
    lock_in = 1'b0;
    push(cyc + 3, 1'b1, 1'b1, 8'h20, "R4 R9 lock fall pulse mode 11");
    push(cyc + 4, 1'b1, 1'b0, 8'h20, "R9 pulse one cycle");
    idle(5);
    clear(8'h00, "R8 clear");

    // R6 R7 gpio change
    write_en(8'h40);
    gpio_in = 1'b1;
    push(cyc + 2, 1'b0, 1'b0, 8'h40, "R6 level visible before alert");
    push(cyc + 3, 1'b1, 1'b1, 8'h40, "R7 gpio rise sets alert");
    idle(5);
    clear(8'h40, "R6 level not cleared");
    gpio_in = 1'b0;
    push(cyc + 3, 1'b1, 1'b1, 8'h00, "R7 gpio fall sets alert");
    idle(5);
    clear(8'h00, "R8 clear");

    write_en(8'h00);
    gpio_in = 1'b1;
    push(cyc + 3, 1'b0, 1'b0, 8'h40, "R7 change disabled");
    idle(5);

    // R5 falling ignored
    gpio_mode = 2'b10;
    write_en(8'h03);
    oc_left_in = 1'b0;
    push(cyc + 3, 1'b0, 1'b0, 8'h40, "R5 falling edge ignored");
    idle(5);
    oc_left_in = 1'b1;
    push(cyc + 3, 1'b1, 1'b1, 8'h42, "R5 ocl rise");
    idle(5);

    // R8 collision of clear and new event, R10 no pulse
    oc_right_in = 1'b1;
    push(cyc + 3, 1'b1, 1'b0, 8'h41, "R8 collision keeps alert");
    push(cyc + 4, 1'b1, 1'b0, 8'h41, "R10 collision no pulse");
    idle(2);
    rd_clr = 1'b1;
    idle(1);
    rd_clr = 1'b0;
    idle(3);
    clear(8'h40, "R8 final clear");

    idle(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule